// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a stream of 10-bit parallel words into a single serial bit stream. Each word travels in a 12-bit frame that carries its own timing: a start bit at logic 1, the ten data bits least significant first, and a stop bit at logic 0. Every frame boundary therefore shows a rising edge that a receiver can lock to. The block runs on a bit-rate clock at twelve times the word rate. The word clock arrives as a level input sampled on that bit clock, and a select input decides which of its edges captures the parallel word.

Two independent sync request inputs are ORed together. Either one makes the block send training frames of six ones followed by six zeros in place of data. An active-low power-down input resets the serializer and disables the output. When it is released, the block sends a fixed number of training frames before it carries data, and it flags this period on `init_busy`. A separate active-low driver enable only gates the output-enable flag. The serial sequence keeps running underneath, so the link resumes exactly where it would have been.

Top module: `ecs_serializer`

## Requirements
- R1: Outside power-down and reset, a new frame starts every 12 bit-clock cycles and each frame takes exactly 12 bit times on `sdata`.
- R2: A data frame sends 1, then `din` bits 0 through 9 in ascending order, then 0.
- R3: With `edge_sel` = 0, `din` is captured in the cycle where the sampled `tclk` changes from 0 to 1. With `edge_sel` = 1, it is captured where `tclk` changes from 1 to 0. A data frame carries the most recent word captured before the frame starts.
- R4: If `sync_a` or `sync_b` is high at a frame boundary, the next frame is a training frame (six 1 bits then six 0 bits). Such a frame always completes in full, and training frames repeat for as long as either request stays high.
- R5: While `pd_n` is low at a clock edge, `sdata` is 0 after that edge and all framing, capture and initialisation state returns to its reset value.
- R6: After reset or after `pd_n` returns high, the first INIT_FRAMES frames are training frames. `init_busy` is 1 from reset until the first frame that follows them begins.
- R7: `den` low has no effect on `sdata` or `init_busy`. The bit sequence continues unchanged while it is low and after it returns high.
- R8: `oe` equals `den` AND `pd_n` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, 12 per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk | input | 1 | Word clock level, synchronous to clk |
| edge_sel | input | 1 | 0: capture on tclk rise, 1: on tclk fall |
| din | input | 10 | Parallel data word |
| sync_a | input | 1 | Training request, first source |
| sync_b | input | 1 | Training request, second source |
| pd_n | input | 1 | Active-low power-down, sampled on clk |
| den | input | 1 | Active-low output disable (1 = drive) |
| sdata | output | 1 | Serial data bit |
| oe | output | 1 | Output-enable flag for the line driver |
| init_busy | output | 1 | High while post-reset training is in progress |

## Verification
The assertions assume that every input is synchronous to `clk` and does not change between edges. In particular, `tclk` is a level that a divider in the same clock domain produces, and `pd_n` is not a raw asynchronous pin. The bench drives all inputs a short delay after the rising edge and derives `tclk` from a counter on `clk`, which satisfies these assumptions. It also changes `edge_sel` only while the word clock runs, so the capture assertion always sees a settled previous sample.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

   typedef enum logic {
      FK_DATA = 1'b0,
      FK_SYNC = 1'b1
   } frame_kind_e;

endpackage

// File: rtl/ecs_word_capture.sv
module ecs_word_capture #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              tclk,
   input  logic              edge_sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] word_q
);

   logic tclk_q;
   logic cap_stb;

   always_comb begin
      if (edge_sel) cap_stb = tclk_q & ~tclk;
      else          cap_stb = ~tclk_q & tclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk_q <= 1'b0;
         word_q <= '0;
      end else begin
         tclk_q <= tclk;
         if (!pd_n)        word_q <= '0;
         else if (cap_stb) word_q <= din;
      end
   end

   // R3: a detected edge loads the word present at that edge
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb && pd_n) |=> (word_q == $past(din)));

   // R3: no edge, no change
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_stb && pd_n) |=> $stable(word_q));

endmodule

// File: rtl/ecs_init_ctrl.sv
module ecs_init_ctrl #(
   parameter int INIT_FRAMES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic frame_load,
   output logic train_req,
   output logic init_busy
);

   localparam int CNT_W = $clog2(INIT_FRAMES + 1);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_FRAMES);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign train_req = (cnt_q != '0);
   assign init_busy = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_INIT;
         busy_q <= 1'b1;
      end else if (!pd_n) begin
         cnt_q  <= CNT_INIT;
         busy_q <= 1'b1;
      end else if (frame_load) begin
         busy_q <= train_req;
         if (train_req) cnt_q <= cnt_q - 1'b1;
      end
   end

   // R6: a frame started while training remains keeps the busy flag up
   a_r6_busy_training: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && train_req && pd_n) |=> init_busy);

   // R6: the flag never rises again without a power-down
   a_r6_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_busy && pd_n) |=> !init_busy);

endmodule

// File: rtl/ecs_frame_shifter.sv
module ecs_frame_shifter
   import ecs_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              sync_req,
   input  logic              train_req,
   input  logic [DATA_W-1:0] word,
   output logic              sdata,
   output logic              frame_load
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int HALF    = FRAME_W / 2;
   localparam int SLOT_W  = $clog2(FRAME_W);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

   logic [SLOT_W-1:0]  slot_q;
   logic [FRAME_W-1:0] fr_q;
   logic [FRAME_W-1:0] sync_pat;
   logic [FRAME_W-1:0] data_pat;
   logic [FRAME_W-1:0] next_fr;
   logic               sd_q;
   frame_kind_e        kind_q;
   frame_kind_e        next_kind;

   for (genvar i = 0; i < FRAME_W; i++) begin : g_sync
      if (i < HALF) begin : g_one
         assign sync_pat[i] = 1'b1;
      end else begin : g_zero
         assign sync_pat[i] = 1'b0;
      end
   end

   assign data_pat   = {1'b0, word, 1'b1};
   assign next_kind  = (sync_req || train_req) ? FK_SYNC : FK_DATA;
   assign next_fr    = (next_kind == FK_SYNC) ? sync_pat : data_pat;
   assign frame_load = (slot_q == LAST) && pd_n;
   assign sdata      = sd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= LAST;
         fr_q   <= '0;
         sd_q   <= 1'b0;
         kind_q <= FK_DATA;
      end else if (!pd_n) begin
         slot_q <= LAST;
         fr_q   <= '0;
         sd_q   <= 1'b0;
         kind_q <= FK_DATA;
      end else if (slot_q == LAST) begin
         slot_q <= '0;
         fr_q   <= next_fr >> 1;
         sd_q   <= next_fr[0];
         kind_q <= next_kind;
      end else begin
         slot_q <= slot_q + 1'b1;
         fr_q   <= fr_q >> 1;
         sd_q   <= fr_q[0];
      end
   end

   // R1: slot counter stays inside the frame
   a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= LAST);

   // R1: after a load the next one is a full frame away
   a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));

   // R2: every frame begins with the start bit
   a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == '0) |-> sdata);

   // R2: every frame ends with the stop bit
   a_r2_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == LAST) |-> !sdata);

   // R4: a request at the boundary gives a training frame
   a_r4_sync_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && sync_req) |=> (kind_q == FK_SYNC));

   // R4: training pattern turns to zeros at mid-frame
   a_r4_sync_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == FK_SYNC && slot_q == SLOT_W'(HALF)) |-> !sdata);

endmodule

// File: rtl/ecs_serializer.sv
module ecs_serializer #(
   parameter int DATA_W      = 10,
   parameter int INIT_FRAMES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tclk,
   input  logic              edge_sel,
   input  logic [DATA_W-1:0] din,
   input  logic              sync_a,
   input  logic              sync_b,
   input  logic              pd_n,
   input  logic              den,
   output logic              sdata,
   output logic              oe,
   output logic              init_busy
);

   initial begin
      assert (DATA_W >= 2 && (DATA_W % 2) == 0)
         else $error("DATA_W must be even and at least 2");
      assert (INIT_FRAMES >= 1)
         else $error("INIT_FRAMES must be at least 1");
   end

   logic [DATA_W-1:0] word_q;
   logic              frame_load;
   logic              train_req;
   logic              sync_req;

   assign sync_req = sync_a | sync_b;
   assign oe       = den & pd_n;

   ecs_word_capture #(.DATA_W(DATA_W)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_n     (pd_n),
      .tclk     (tclk),
      .edge_sel (edge_sel),
      .din      (din),
      .word_q   (word_q)
   );

   ecs_init_ctrl #(.INIT_FRAMES(INIT_FRAMES)) init_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .frame_load (frame_load),
      .train_req  (train_req),
      .init_busy  (init_busy)
   );

   ecs_frame_shifter #(.DATA_W(DATA_W)) shf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .sync_req   (sync_req),
      .train_req  (train_req),
      .word       (word_q),
      .sdata      (sdata),
      .frame_load (frame_load)
   );

   // R5: power-down silences the line on the next edge
   a_r5_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> !sdata);

   // R8: no drive during power-down
   a_r8_pd_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |-> !oe);

   // R6: leaving power-down always starts with a training period
   a_r6_pd_exit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_n) |-> init_busy);

endmodule

// File: tb/ecs_serializer_tb.sv
module ecs_serializer_tb_top;

   localparam int DW    = 10;
   localparam int FW    = DW + 2;
   localparam int NINIT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tclk = 1'b0;
   logic          edge_sel = 1'b0;
   logic [DW-1:0] din = '0;
   logic          sync_a = 1'b0;
   logic          sync_b = 1'b0;
   logic          pd_n = 1'b1;
   logic          den = 1'b1;
   logic          sdata, oe, init_busy;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R6";
   bit    cmp_on   = 1'b0;
   bit    tclk_run = 1'b0;

   always #10 clk = ~clk;

   ecs_serializer #(.DATA_W(DW), .INIT_FRAMES(NINIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .tclk(tclk), .edge_sel(edge_sel), .din(din),
      .sync_a(sync_a), .sync_b(sync_b), .pd_n(pd_n), .den(den),
      .sdata(sdata), .oe(oe), .init_busy(init_busy)
   );

   // reference model
   bit          m_tq, m_sd, m_busy;
   bit [DW-1:0] m_hold;
   int          m_slot, m_init;
   bit          m_bits[FW];
   int          m_div;

   always @(posedge clk) begin
      bit edge_hit;
      if (!rst_n || !pd_n) begin
         if (!rst_n) m_tq = 1'b0; else m_tq = tclk;
         m_hold = '0; m_slot = FW - 1; m_sd = 1'b0;
         m_init = NINIT; m_busy = 1'b1;
      end else begin
         edge_hit = edge_sel ? (m_tq && !tclk) : (!m_tq && tclk);
         if (m_slot == FW - 1) begin
            if (sync_a || sync_b || m_init > 0) begin
               for (int k = 0; k < FW; k++) m_bits[k] = (k < FW / 2);
            end else begin
               m_bits[0] = 1'b1;
               for (int k = 0; k < DW; k++) m_bits[k+1] = m_hold[k];
               m_bits[FW-1] = 1'b0;
            end
            m_busy = (m_init > 0);
            if (m_init > 0) m_init--;
            m_slot = 0;
         end else begin
            m_slot++;
         end
         m_sd = m_bits[m_slot];
         if (edge_hit) m_hold = din;
         m_tq = tclk;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         check(cur_req, "sdata", int'(sdata), int'(m_sd));
         check("R8", "oe", int'(oe), int'(den & pd_n));
         check(cur_req, "init_busy", int'(init_busy), int'(m_busy));
      end
   end

   // word clock and data source
   always @(posedge clk) begin
      if (tclk_run) begin
         m_div = (m_div + 1) % FW;
         #2;
         if (m_div == 0) tclk <= 1'b1;
         if (m_div == FW / 2) tclk <= 1'b0;
         if (m_div == 3 || m_div == 9) din <= DW'($urandom);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      m_div = 0;
      step(3);
      #5;
      check("R5", "reset sdata", int'(sdata), 0);
      check("R6", "reset init_busy", int'(init_busy), 1);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      tclk_run = 1'b1;
      cur_req = "R6";
      step(NINIT * FW + 4);
      cur_req = "R2/R3 rising";
      step(300);
      cur_req = "R3 falling";
      edge_sel = 1'b1;
      step(300);
      edge_sel = 1'b0;
      cur_req = "R4 short pulse";
      sync_a = 1'b1; step(2); sync_a = 1'b0;
      step(60);
      cur_req = "R4 held";
      sync_b = 1'b1; step(50); sync_b = 1'b0;
      step(40);
      cur_req = "R7";
      den = 1'b0;
      step(3);
      check("R7", "oe with den low", int'(oe), 0);
      step(50);
      den = 1'b1;
      step(30);
      cur_req = "R5";
      pd_n = 1'b0;
      step(3);
      check("R5", "sdata in power-down", int'(sdata), 0);
      check("R8", "oe in power-down", int'(oe), 0);
      step(30);
      pd_n = 1'b1;
      cur_req = "R6 after power-down";
      step(1);
      check("R6", "busy after exit", int'(init_busy), 1);
      step(NINIT * FW + 4);
      check("R6", "busy cleared", int'(init_busy), 0);
      cur_req = "R1/R2";
      step(200);
      cmp_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule